// File: doc/BRIEF.md
# Masked Comma Word Aligner

This block sits right after a deserializer. It takes parallel words whose symbol boundaries are not known and looks for a comma at every bit offset of the stream. Each cycle it joins the word held from the last cycle to the word arriving now, then tests every offset within one word width at once. Each offset is tested against a plus comma and a minus comma. Both commas share one care mask, so a position whose mask bit is clear never blocks a match.

When a comma is found, the aligner records its offset. It then delivers words shifted so that the first comma bit sits at bit 0. It keeps that offset until a comma turns up somewhere else. A double-comma mode accepts only a plus comma directly followed by a minus comma, treated as one 20-bit pattern. When the enable input is low, the block steps aside and the input word goes straight to the output with no register in the path.

Top module: `cwa_aligner`

## Requirements
- R1: While `en_i` is low, `data_o` equals `data_i` in the same cycle, bit for bit, with no register in the path.
- R2: While `en_i` is low, no search takes place: in the cycle after any cycle with `en_i` low, `comma_o` and `realign_o` are low, even if the stream contains a comma.
- R3: Bits arrive least significant bit first, and word k carries stream bits 20k..20k+19. In single mode, a comma at an offset is found when the 10 stream bits starting there equal the plus or the minus value on every cared-for position. Pattern bit i is compared with the i-th stream bit of the comma.
- R4: A mask bit of 0 makes that pattern position a don't-care for both comma values. A mask bit of 1 makes that position count.
- R5: One clock after the word that completes a comma, `data_o` holds the 20 stream bits that start at the first comma bit, and `comma_o` is high for that one cycle.
- R6: After a comma, the chosen offset is kept for later words until a comma appears at another offset, so the next output holds the following 20 stream bits.
- R7: If several offsets match in the same cycle, the lowest offset wins.
- R8: `realign_o` pulses together with `comma_o` only when the new offset differs from the held one. A comma at the held offset, including offset 0 after reset, gives no pulse.
- R9: With `dbl_i` high, a match needs the plus comma immediately followed by the minus comma. A plus comma on its own is not detected.
- R10: Reset sets the held offset to 0 and clears `comma_o`, `realign_o` and the output word. At offset 0 the output is the previous input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1: search and align; 0: direct pass-through |
| dbl_i | input | 1 | 1: require the plus comma followed by the minus comma |
| plus_i | input | 10 | Plus comma value, bit 0 compared first |
| minus_i | input | 10 | Minus comma value, bit 0 compared first |
| mask_i | input | 10 | Care mask shared by both commas, 1 = compare |
| data_i | input | 20 | Unaligned word from the deserializer, bit 0 earliest |
| data_o | output | 20 | Aligned word, or `data_i` when bypassed |
| comma_o | output | 1 | Output word starts with a comma |
| realign_o | output | 1 | The held offset changed with this comma |

## Verification
Each stream is built as a bit sequence with commas planted at chosen bit positions, so the expected cycle and output slice follow directly from the position.

- A lone plus comma and a lone minus comma at the same offset show that both values are recognised, and that a repeat at the same offset does not raise a realign pulse.
- A comma at offset 0 and a second comma at a new offset separate a held offset from a moved one.
- Two commas visible in one window check the lowest-offset rule.
- A corrupted comma is sent once with a partial mask and once with a full mask, which shows the don't-care positions.
- In double mode, a plus-then-minus pair is sent alongside a plus comma on its own.
- Bypass streams carry a comma and check that it is passed through untouched and never flagged.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    localparam int unsigned COMMA_W_DEF = 10;

    // True when every cared-for bit of the slice equals the pattern.
    function automatic logic masked_eq(
        input logic [COMMA_W_DEF-1:0] bits,
        input logic [COMMA_W_DEF-1:0] pattern,
        input logic [COMMA_W_DEF-1:0] care
    );
        return ((bits ^ pattern) & care) == '0;
    endfunction

endpackage

// File: rtl/cwa_offset_match.sv
module cwa_offset_match
    import cwa_pkg::*;
#(
    parameter int unsigned DATA_W  = 20,
    parameter int unsigned COMMA_W = COMMA_W_DEF
) (
    input  logic [2*DATA_W-1:0]  window_i,
    input  logic [COMMA_W-1:0]   plus_i,
    input  logic [COMMA_W-1:0]   minus_i,
    input  logic [COMMA_W-1:0]   mask_i,
    input  logic                 dbl_i,
    output logic [DATA_W-1:0]    hit_o
);

    localparam bit DBL_OK = (DATA_W >= 2 * COMMA_W);

    for (genvar o = 0; o < DATA_W; o++) begin : g_off
        logic [COMMA_W-1:0] first_d;
        logic               p_hit_d;
        logic               m_hit_d;

        assign first_d = window_i[o +: COMMA_W];
        assign p_hit_d = masked_eq(first_d, plus_i, mask_i);
        assign m_hit_d = masked_eq(first_d, minus_i, mask_i);

        if (DBL_OK) begin : g_dbl
            logic [COMMA_W-1:0] second_d;
            logic               pair_d;
            assign second_d = window_i[o + COMMA_W +: COMMA_W];
            assign pair_d   = p_hit_d && masked_eq(second_d, minus_i, mask_i);
            assign hit_o[o] = dbl_i ? pair_d : (p_hit_d || m_hit_d);
        end else begin : g_single
            assign hit_o[o] = p_hit_d || m_hit_d;
        end
    end

endmodule

// File: rtl/cwa_lowest_pick.sv
module cwa_lowest_pick #(
    parameter int unsigned N    = 20,
    localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = i[IW-1:0];
                any_o = 1'b1;
            end
        end
    end

    logic [N-1:0] below_d;
    assign below_d = (N'(1) << idx_o) - N'(1);

    always_comb begin
        if (any_o) begin
            assert_lowest_R7: assert (req_i[idx_o] && ((req_i & below_d) == '0))
                else $error("picked offset is not the lowest match");
        end
    end

endmodule

// File: rtl/cwa_aligner.sv
module cwa_aligner
    import cwa_pkg::*;
#(
    parameter int unsigned DATA_W  = 20,
    parameter int unsigned COMMA_W = COMMA_W_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               dbl_i,
    input  logic [COMMA_W-1:0] plus_i,
    input  logic [COMMA_W-1:0] minus_i,
    input  logic [COMMA_W-1:0] mask_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [DATA_W-1:0]  data_o,
    output logic               comma_o,
    output logic               realign_o
);

    localparam int unsigned OFF_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int unsigned WIN_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] prev;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
        logic              comma;
        logic              realign;
    } state_t;

    state_t st_d, st_q;

    logic [WIN_W-1:0]  window_d;
    logic [WIN_W-1:0]  shifted_d;
    logic [DATA_W-1:0] hit_d;
    logic [OFF_W-1:0]  pick_d;
    logic              any_d;
    logic [OFF_W-1:0]  off_sel_d;

    assign window_d = {data_i, st_q.prev};

    cwa_offset_match #(
        .DATA_W  (DATA_W),
        .COMMA_W (COMMA_W)
    ) u_match (
        .window_i (window_d),
        .plus_i   (plus_i),
        .minus_i  (minus_i),
        .mask_i   (mask_i),
        .dbl_i    (dbl_i),
        .hit_o    (hit_d)
    );

    cwa_lowest_pick #(
        .N (DATA_W)
    ) u_pick (
        .req_i (hit_d),
        .idx_o (pick_d),
        .any_o (any_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = data_i;
        off_sel_d = any_d ? pick_d : st_q.off;
        shifted_d = window_d >> off_sel_d;
        if (en_i) begin
            st_d.off     = off_sel_d;
            st_d.data    = shifted_d[DATA_W-1:0];
            st_d.comma   = any_d;
            st_d.realign = any_d && (pick_d != st_q.off);
        end else begin
            st_d.comma   = 1'b0;
            st_d.realign = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o    = en_i ? st_q.data : data_i;
    assign comma_o   = st_q.comma;
    assign realign_o = st_q.realign;

    assert_realign_has_comma_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        realign_o |-> comma_o);

    assert_realign_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        realign_o |-> (st_q.off != $past(st_q.off)));

    assert_offset_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !any_d) |=> $stable(st_q.off));

    assert_quiet_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!comma_o && !realign_o));

endmodule

// File: tb/tb_cwa_aligner.sv
module tb_cwa_aligner;

    localparam int DW = 20;
    localparam int SB = 256;
    localparam logic [9:0] PLUS  = 10'b0011111010;
    localparam logic [9:0] MINUS = 10'b1100000101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b1;
    logic          dbl = 1'b0;
    logic [9:0]    plus = PLUS;
    logic [9:0]    minus = MINUS;
    logic [9:0]    mask = 10'h3FF;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          comma;
    logic          realign;

    int checks = 0;
    int fails = 0;

    logic          stream [0:SB-1];
    logic [DW-1:0] cap_data [0:15];
    logic          cap_comma [0:15];
    logic          cap_realign [0:15];

    always #4 clk = ~clk;

    cwa_aligner #(.DATA_W(DW), .COMMA_W(10)) dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dbl_i(dbl),
        .plus_i(plus), .minus_i(minus), .mask_i(mask),
        .data_i(din), .data_o(dout), .comma_o(comma), .realign_o(realign)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        din = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_stream();
        for (int i = 0; i < SB; i++) stream[i] = 1'b0;
    endtask

    task automatic put(input logic [9:0] pat, input int pos);
        for (int i = 0; i < 10; i++) stream[pos + i] = pat[i];
    endtask

    function automatic logic [DW-1:0] slice(input int pos);
        logic [DW-1:0] s;
        for (int j = 0; j < DW; j++) s[j] = stream[pos + j];
        return s;
    endfunction

    // Feeds n words; output after word k is stored at index k.
    task automatic run(input int n, input bit bypass_chk);
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (k > 0) begin
                cap_data[k-1]    = dout;
                cap_comma[k-1]   = comma;
                cap_realign[k-1] = realign;
            end
            if (k < n) begin
                din = slice(DW * k);
                if (bypass_chk) begin
                    #1;
                    chk(dout == din, "R1 bypass data", 32'(dout), 32'(din));
                end
            end
        end
        din = '0;
    endtask

    task automatic t_reset();
        en = 1'b1; dbl = 1'b0; mask = 10'h3FF;
        do_reset();
        chk(comma == 1'b0 && realign == 1'b0, "R10 flags after reset", {30'b0, comma, realign}, 32'h0);
        chk(dout == '0, "R10 data after reset", 32'(dout), 32'h0);
        clear_stream();
        stream[0] = 1'b1; stream[1] = 1'b1;
        run(2, 1'b0);
        chk(cap_data[0] == '0, "R10 offset zero first word", 32'(cap_data[0]), 32'h0);
        chk(cap_data[1] == 20'h3, "R10 offset zero previous word", 32'(cap_data[1]), 32'h3);
    endtask

    task automatic t_single();
        do_reset();
        clear_stream();
        put(PLUS, 27);
        put(MINUS, 67);
        run(6, 1'b0);
        chk(cap_comma[1] == 1'b0, "R5 no early comma", 32'(cap_comma[1]), 32'h0);
        chk(cap_data[2] == slice(27), "R5 aligned plus word", 32'(cap_data[2]), 32'(slice(27)));
        chk(cap_comma[2] && cap_realign[2], "R3 R8 plus found with realign",
            {30'b0, cap_comma[2], cap_realign[2]}, 32'h3);
        chk(cap_data[3] == slice(47) && !cap_comma[3], "R6 offset held",
            32'(cap_data[3]), 32'(slice(47)));
        chk(cap_comma[4] && !cap_realign[4], "R3 R8 minus at same offset",
            {30'b0, cap_comma[4], cap_realign[4]}, 32'h2);
        chk(cap_data[4] == slice(67), "R5 aligned minus word", 32'(cap_data[4]), 32'(slice(67)));
    endtask

    task automatic t_off_zero();
        do_reset();
        clear_stream();
        put(PLUS, 40);
        run(5, 1'b0);
        chk(cap_comma[3] && !cap_realign[3], "R8 comma at offset zero, no realign",
            {30'b0, cap_comma[3], cap_realign[3]}, 32'h2);
        chk(cap_data[3] == slice(40), "R5 offset zero word", 32'(cap_data[3]), 32'(slice(40)));
    endtask

    task automatic t_move();
        do_reset();
        clear_stream();
        put(PLUS, 27);
        put(PLUS, 73);
        run(6, 1'b0);
        chk(cap_comma[4] && cap_realign[4], "R8 realign on offset move",
            {30'b0, cap_comma[4], cap_realign[4]}, 32'h3);
        chk(cap_data[4] == slice(73), "R6 new offset word", 32'(cap_data[4]), 32'(slice(73)));
        chk(cap_data[5] == slice(93), "R6 new offset held", 32'(cap_data[5]), 32'(slice(93)));
    endtask

    task automatic t_mask();
        do_reset();
        clear_stream();
        put(10'b0011111101, 27);
        mask = 10'b1111111000;
        run(5, 1'b0);
        chk(cap_comma[2] == 1'b1, "R4 masked bits ignored", 32'(cap_comma[2]), 32'h1);
        chk(cap_data[2] == slice(27), "R4 masked comma aligned", 32'(cap_data[2]), 32'(slice(27)));
        mask = 10'h3FF;
        do_reset();
        run(5, 1'b0);
        for (int k = 0; k < 5; k++)
            chk(cap_comma[k] == 1'b0, "R4 full mask rejects", 32'(cap_comma[k]), 32'h0);
    endtask

    task automatic t_lowest();
        do_reset();
        clear_stream();
        put(PLUS, 22);
        put(PLUS, 33);
        run(4, 1'b0);
        chk(cap_comma[2] == 1'b1, "R7 comma seen", 32'(cap_comma[2]), 32'h1);
        chk(cap_data[2] == slice(22), "R7 lowest offset chosen", 32'(cap_data[2]), 32'(slice(22)));
    endtask

    task automatic t_double();
        dbl = 1'b1;
        do_reset();
        clear_stream();
        put(PLUS, 45);
        put(MINUS, 55);
        run(5, 1'b0);
        chk(cap_comma[3] && cap_realign[3], "R9 pair detected",
            {30'b0, cap_comma[3], cap_realign[3]}, 32'h3);
        chk(cap_data[3] == slice(45), "R9 pair aligned", 32'(cap_data[3]), 32'(slice(45)));
        do_reset();
        clear_stream();
        put(PLUS, 45);
        run(5, 1'b0);
        for (int k = 0; k < 5; k++)
            chk(cap_comma[k] == 1'b0, "R9 lone plus rejected", 32'(cap_comma[k]), 32'h0);
        dbl = 1'b0;
    endtask

    task automatic t_bypass();
        do_reset();
        en = 1'b0;
        clear_stream();
        put(PLUS, 27);
        stream[3] = 1'b1;
        run(5, 1'b1);
        for (int k = 0; k < 5; k++)
            chk(!cap_comma[k] && !cap_realign[k], "R2 no flags in bypass",
                {30'b0, cap_comma[k], cap_realign[k]}, 32'h0);
        en = 1'b1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_off_zero();
        t_move();
        t_mask();
        t_lowest();
        t_double();
        t_bypass();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule